// File: doc/BRIEF.md
# Symbol Bus Width and Edge-Rate Converter

This block sits between a link-layer controller and a physical-layer transceiver and moves 8-bit symbols, each tagged with a control (K) flag, between two bus shapes. One shape is a 16-bit bus that carries two symbols on every rising clock edge. The other is an 8-bit bus that carries one symbol per clock edge, using both edges. The transmit direction turns a 16-bit word from the controller into either a registered 16-bit word or a pair of half-period symbols. The receive direction rebuilds 16-bit words from either bus shape and hands them back with their K pair and a valid flag.

A single select input chooses the bus shape. It is taken only while reset is held, so the shape stays fixed for the whole run between two resets. Sideband qualifiers such as the receive valid flag are single-rate in both shapes and are sampled once per clock period, on the rising edge. Pads, pad timing and line coding are not part of the block.

Top module: `sym_width_bridge`

## Requirements
- R1: Reset is synchronous and active high. After any rising edge with `rst` high, every output is zero. The 8-bit transmit outputs stay zero through the falling edge of that period.
- R2: `ddr_sel` is captured on every rising edge while `rst` is high, with 1 selecting the dual-edge shape and 0 the 16-bit shape. The value seen at the last reset edge sets the shape. Changes of `ddr_sel` while `rst` is low have no effect on any output.
- R3: In 16-bit shape, the transmit word and K pair sampled on a rising edge appear on `phy_tx_wide_data`/`phy_tx_wide_k` after that edge. Symbol N is in bits [7:0] with K bit 0, and symbol N+1 is in bits [15:8] with K bit 1. The 8-bit transmit outputs are zero.
- R4: In dual-edge shape, the word sampled on a rising edge is sent as follows. Its low symbol (bits [7:0] with K bit 0) is on `phy_tx_ddr_data`/`phy_tx_ddr_k` from that rising edge to the next falling edge. Its high symbol (bits [15:8] with K bit 1) is on those outputs from that falling edge to the next rising edge. The 16-bit transmit outputs are zero.
- R5: In 16-bit shape, `mac_rx_data`, `mac_rx_k` and `mac_rx_valid` show, after a rising edge, the values of `phy_rx_wide_data`, `phy_rx_wide_k` and `phy_rx_valid` sampled on that edge.
- R6: In dual-edge shape, the 8-bit symbol sampled on a rising edge becomes bits [7:0] and K bit 0 of a word. The symbol sampled on the following falling edge becomes bits [15:8] and K bit 1. The word is presented after the next rising edge, one full clock after the low symbol was taken, with `mac_rx_valid` equal to `phy_rx_valid` sampled together with the low symbol.
- R7: With the dual-edge transmit outputs fed into the dual-edge receive inputs with a quarter-period shift, every transmitted word and K pair comes back unchanged and in order, two clock periods after it was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; rising and falling edges both used |
| rst | input | 1 | Synchronous active-high reset |
| ddr_sel | input | 1 | Bus shape select, taken during reset (1 = dual-edge) |
| mac_tx_data | input | 16 | Transmit word from the controller, symbol N in [7:0] |
| mac_tx_k | input | 2 | K flags of the transmit word, bit 0 for [7:0] |
| phy_tx_wide_data | output | 16 | 16-bit transmit bus to the transceiver |
| phy_tx_wide_k | output | 2 | K flags of the 16-bit transmit bus |
| phy_tx_ddr_data | output | 8 | Dual-edge transmit symbol |
| phy_tx_ddr_k | output | 1 | K flag of the dual-edge transmit symbol |
| phy_rx_wide_data | input | 16 | 16-bit receive bus from the transceiver |
| phy_rx_wide_k | input | 2 | K flags of the 16-bit receive bus |
| phy_rx_ddr_data | input | 8 | Dual-edge receive symbol |
| phy_rx_ddr_k | input | 1 | K flag of the dual-edge receive symbol |
| phy_rx_valid | input | 1 | Receive valid sideband, single-rate |
| mac_rx_data | output | 16 | Rebuilt receive word to the controller |
| mac_rx_k | output | 2 | K flags of the rebuilt receive word |
| mac_rx_valid | output | 1 | Valid flag of the rebuilt receive word |

## Verification
On every rising edge, the assertions check four things. The latched shape never moves outside reset. The inactive transmit bus stays at zero. The symbol seen in the low phase is the high half of the word taken one edge earlier. In dual-edge receive, the low half and the valid flag of each output word match what was sampled two edges before. The order of the two symbols within one period, the exact half-period in which the low transmit symbol appears, the effect of a reset in mid-stream and the full loopback round trip span both edges and several periods. Only the bench's scenarios can show these, using a reference model that predicts each half-period value.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    localparam int SYM_BITS  = 8;
    localparam int LANES     = 2;
    localparam int WORD_BITS = SYM_BITS * LANES;
    localparam int LO_LANE   = 0;
    localparam int HI_LANE   = LANES - 1;

    typedef struct packed {
        logic                k;
        logic [SYM_BITS-1:0] d;
    } sym_t;

    typedef sym_t [LANES-1:0] word_t;

    typedef enum logic {
        MODE_WIDE = 1'b0,
        MODE_DDR  = 1'b1
    } bus_mode_e;

    function automatic sym_t sym_mix(input sym_t a, input sym_t b);
        return sym_t'(a ^ b);
    endfunction

    function automatic sym_t make_sym(input logic k, input logic [SYM_BITS-1:0] d);
        sym_t s;
        s.k = k;
        s.d = d;
        return s;
    endfunction
endpackage

// File: rtl/sbr_mode_latch.sv
module sbr_mode_latch
    import sbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_i,
    output bus_mode_e mode_o
);
    bus_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= sel_i ? MODE_DDR : MODE_WIDE;
        end
    end

    assign mode_o = mode_q;

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst)) |-> $stable(mode_q));
endmodule

// File: rtl/sbr_tx_path.sv
module sbr_tx_path
    import sbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_mode_e mode_i,
    input  word_t     word_i,
    output word_t     wide_o,
    output sym_t      ddr_o
);
    logic  ddr_en;
    word_t wide_q;
    sym_t  rise_q;
    sym_t  fall_q;
    sym_t  hi_hold_q;
    logic  run_q;

    assign ddr_en = (mode_i == MODE_DDR);

    // Rising-edge half: registered wide word and the rising half of the XOR pair.
    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q    <= '0;
            rise_q    <= '0;
            hi_hold_q <= '0;
            run_q     <= 1'b0;
        end else begin
            run_q     <= ddr_en;
            wide_q    <= ddr_en ? word_t'('0) : word_i;
            rise_q    <= sym_mix(ddr_en ? word_i[LO_LANE] : sym_t'('0), fall_q);
            hi_hold_q <= ddr_en ? word_i[HI_LANE] : sym_t'('0);
        end
    end

    // Falling-edge half: folds the high symbol into the pair.
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= '0;
        end else begin
            fall_q <= sym_mix(hi_hold_q, rise_q);
        end
    end

    assign wide_o = wide_q;
    assign ddr_o  = run_q ? sym_mix(rise_q, fall_q) : sym_t'('0);

    // R4
    tx_hi_order_chk: assert property (@(posedge clk) disable iff (rst)
        ddr_en |=> (ddr_o == $past(word_i[HI_LANE])));

    // R4
    tx_wide_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ddr_en |=> (wide_o == '0));

    // R3
    tx_ddr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ddr_en) |=> (ddr_o == '0));
endmodule

// File: rtl/sbr_rx_path.sv
module sbr_rx_path
    import sbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_mode_e mode_i,
    input  word_t     wide_i,
    input  sym_t      ddr_i,
    input  logic      vld_i,
    output word_t     word_o,
    output logic      vld_o
);
    logic  ddr_en;
    sym_t  lo_q;
    sym_t  hi_q;
    logic  lo_vld_q;
    word_t out_q;
    logic  out_vld_q;
    word_t joined;

    assign ddr_en = (mode_i == MODE_DDR);

    always_comb begin
        joined          = '0;
        joined[LO_LANE] = lo_q;
        joined[HI_LANE] = hi_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q      <= '0;
            lo_vld_q  <= 1'b0;
            out_q     <= '0;
            out_vld_q <= 1'b0;
        end else begin
            lo_q      <= ddr_i;
            lo_vld_q  <= vld_i;
            out_q     <= ddr_en ? joined : wide_i;
            out_vld_q <= ddr_en ? lo_vld_q : vld_i;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else begin
            hi_q <= ddr_i;
        end
    end

    assign word_o = out_q;
    assign vld_o  = out_vld_q;

    // R6
    rx_lo_order_chk: assert property (@(posedge clk) disable iff (rst)
        (ddr_en && !$past(rst) && !$past(rst, 2)) |-> (word_o[LO_LANE] == $past(ddr_i, 2)));

    // R6
    rx_vld_align_chk: assert property (@(posedge clk) disable iff (rst)
        (ddr_en && !$past(rst) && !$past(rst, 2)) |-> (vld_o == $past(vld_i, 2)));
endmodule

// File: rtl/sym_width_bridge.sv
module sym_width_bridge
    import sbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ddr_sel,
    input  logic [WORD_BITS-1:0] mac_tx_data,
    input  logic [LANES-1:0]     mac_tx_k,
    output logic [WORD_BITS-1:0] phy_tx_wide_data,
    output logic [LANES-1:0]     phy_tx_wide_k,
    output logic [SYM_BITS-1:0]  phy_tx_ddr_data,
    output logic                 phy_tx_ddr_k,
    input  logic [WORD_BITS-1:0] phy_rx_wide_data,
    input  logic [LANES-1:0]     phy_rx_wide_k,
    input  logic [SYM_BITS-1:0]  phy_rx_ddr_data,
    input  logic                 phy_rx_ddr_k,
    input  logic                 phy_rx_valid,
    output logic [WORD_BITS-1:0] mac_rx_data,
    output logic [LANES-1:0]     mac_rx_k,
    output logic                 mac_rx_valid
);
    bus_mode_e mode;
    word_t     tx_word;
    word_t     tx_wide;
    sym_t      tx_ddr;
    word_t     rx_wide;
    sym_t      rx_ddr;
    word_t     rx_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign tx_word[g] = make_sym(mac_tx_k[g], mac_tx_data[g*SYM_BITS +: SYM_BITS]);
        assign rx_wide[g] = make_sym(phy_rx_wide_k[g], phy_rx_wide_data[g*SYM_BITS +: SYM_BITS]);
        assign phy_tx_wide_data[g*SYM_BITS +: SYM_BITS] = tx_wide[g].d;
        assign phy_tx_wide_k[g]                          = tx_wide[g].k;
        assign mac_rx_data[g*SYM_BITS +: SYM_BITS]       = rx_word[g].d;
        assign mac_rx_k[g]                               = rx_word[g].k;
    end

    assign rx_ddr          = make_sym(phy_rx_ddr_k, phy_rx_ddr_data);
    assign phy_tx_ddr_data = tx_ddr.d;
    assign phy_tx_ddr_k    = tx_ddr.k;

    sbr_mode_latch u_mode (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (ddr_sel),
        .mode_o (mode)
    );

    sbr_tx_path u_tx (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .word_i (tx_word),
        .wide_o (tx_wide),
        .ddr_o  (tx_ddr)
    );

    sbr_rx_path u_rx (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .wide_i (rx_wide),
        .ddr_i  (rx_ddr),
        .vld_i  (phy_rx_valid),
        .word_o (rx_word),
        .vld_o  (mac_rx_valid)
    );
endmodule

// File: tb/sym_width_bridge_bench.sv
module sym_width_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ddr_sel = 1'b0;
    logic [15:0] tx_d = '0;
    logic [1:0]  tx_k = '0;
    logic [15:0] rxw_d = '0;
    logic [1:0]  rxw_k = '0;
    logic [8:0]  rx_lb = '0;
    logic        rx_v = 1'b0;

    logic [15:0] tw_d;
    logic [1:0]  tw_k;
    logic [7:0]  td_d;
    logic        td_k;
    logic [15:0] mr_d;
    logic [1:0]  mr_k;
    logic        mr_v;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sym_width_bridge u_sym_width_bridge (
        .clk              (clk),
        .rst              (rst),
        .ddr_sel          (ddr_sel),
        .mac_tx_data      (tx_d),
        .mac_tx_k         (tx_k),
        .phy_tx_wide_data (tw_d),
        .phy_tx_wide_k    (tw_k),
        .phy_tx_ddr_data  (td_d),
        .phy_tx_ddr_k     (td_k),
        .phy_rx_wide_data (rxw_d),
        .phy_rx_wide_k    (rxw_k),
        .phy_rx_ddr_data  (rx_lb[7:0]),
        .phy_rx_ddr_k     (rx_lb[8]),
        .phy_rx_valid     (rx_v),
        .mac_rx_data      (mr_d),
        .mac_rx_k         (mr_k),
        .mac_rx_valid     (mr_v)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Quarter-period shifted loopback of the dual-edge transmit bus (R7)
    initial begin
        logic [8:0] a;
        logic [8:0] b;
        @(posedge clk);
        #1 a = {td_k, td_d};
        forever begin
            #2;
            rx_lb = a;
            b = {td_k, td_d};
            @(posedge clk);
            #1;
            rx_lb = b;
            a = {td_k, td_d};
        end
    end

    // Behavioural reference model, compared every half period
    logic        r_h    [0:1023];
    logic        ddr_h  [0:1023];
    logic        sel_h  [0:1023];
    logic [17:0] tx_h   [0:1023];
    logic [17:0] rxw_h  [0:1023];
    logic        v_h    [0:1023];
    logic [8:0]  elo_h  [0:1023];
    logic [8:0]  ehi_h  [0:1023];

    initial begin
        int   c;
        logic mode_m;
        logic [17:0] e_wide;
        logic [18:0] e_rx;
        string tg;
        c = 0;
        mode_m = 1'b0;
        forever begin
            @(posedge clk);
            r_h[c]   = rst;
            sel_h[c] = ddr_sel;
            ddr_h[c] = mode_m;
            tx_h[c]  = {tx_k, tx_d};
            rxw_h[c] = {rxw_k, rxw_d};
            v_h[c]   = rx_v;
            if (rst) mode_m = ddr_sel;
            if (r_h[c] || !ddr_h[c]) begin
                elo_h[c] = '0;
                ehi_h[c] = '0;
            end else begin
                elo_h[c] = {tx_h[c][16], tx_h[c][7:0]};
                ehi_h[c] = {tx_h[c][17], tx_h[c][15:8]};
            end
            if (r_h[c] || ddr_h[c]) e_wide = '0;
            else e_wide = tx_h[c];
            if (r_h[c]) e_rx = '0;
            else if (!ddr_h[c]) e_rx = {v_h[c], rxw_h[c]};
            else if (c < 2 || r_h[c-1]) e_rx = '0;
            else e_rx = {v_h[c-1], ehi_h[c-2][8], elo_h[c-2][8], ehi_h[c-2][7:0], elo_h[c-2][7:0]};
            #1;
            if (r_h[c]) tg = "R1";
            else if (sel_h[c] != ddr_h[c]) tg = "R2";
            else tg = "";
            chk((tg != "") ? tg : (ddr_h[c] ? "R4" : "R3"), "tx wide", {14'd0, tw_k, tw_d}, {14'd0, e_wide});
            chk((tg != "") ? tg : (ddr_h[c] ? "R4" : "R3"), "tx ddr low symbol", {23'd0, td_k, td_d}, {23'd0, elo_h[c]});
            chk((tg != "") ? tg : (ddr_h[c] ? "R6 R7" : "R5"), "rx word", {14'd0, mr_k, mr_d}, {14'd0, e_rx[17:0]});
            chk((tg != "") ? tg : (ddr_h[c] ? "R6" : "R5"), "rx valid", {31'd0, mr_v}, {31'd0, e_rx[18]});
            #2;
            chk((tg != "") ? tg : (ddr_h[c] ? "R4" : "R3"), "tx ddr high symbol", {23'd0, td_k, td_d}, {23'd0, ehi_h[c]});
            c++;
        end
    end

    task automatic drive(input logic r, input logic s, input logic [15:0] d, input logic [1:0] k,
                         input logic [15:0] rd, input logic [1:0] rk, input logic v);
        @(negedge clk);
        #1;
        rst = r; ddr_sel = s; tx_d = d; tx_k = k; rxw_d = rd; rxw_k = rk; rx_v = v;
    endtask

    task automatic rnd(input logic r, input logic s);
        drive(r, s, 16'($urandom), 2'($urandom), 16'($urandom), 2'($urandom), 1'($urandom));
    endtask

    initial begin
        #(4 * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 16'hA5A5, 2'b11, 16'h5A5A, 2'b11, 1'b1); // R1
        for (int i = 0; i < 30; i++) rnd(1'b0, 1'b0);                                         // R3 R5
        drive(1'b0, 1'b0, 16'hFF00, 2'b10, 16'h00FF, 2'b01, 1'b1);
        drive(1'b0, 1'b0, 16'h00FF, 2'b01, 16'hFF00, 2'b10, 1'b0);
        for (int i = 0; i < 12; i++) rnd(1'b0, 1'b1);                                         // R2
        for (int i = 0; i < 3; i++) rnd(1'b1, 1'b1);                                          // R1 R2
        drive(1'b0, 1'b1, 16'hFFFF, 2'b11, 16'h0, 2'b0, 1'b1);                                // R4 R6
        drive(1'b0, 1'b1, 16'h0000, 2'b00, 16'h0, 2'b0, 1'b0);
        drive(1'b0, 1'b1, 16'h00FF, 2'b01, 16'h0, 2'b0, 1'b1);
        drive(1'b0, 1'b1, 16'hFF00, 2'b10, 16'h0, 2'b0, 1'b1);
        for (int i = 0; i < 40; i++) rnd(1'b0, 1'b1);                                         // R7
        for (int i = 0; i < 10; i++) rnd(1'b0, 1'b0);                                         // R2
        rnd(1'b1, 1'b1);                                                                      // R1 mid-stream
        for (int i = 0; i < 20; i++) rnd(1'b0, 1'b1);
        for (int i = 0; i < 2; i++) rnd(1'b1, 1'b0);
        for (int i = 0; i < 12; i++) rnd(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) @(posedge clk);
        #3;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule